// File: doc/BRIEF.md
# ARINC 429 Receive Channel with Word Checking

This block handles one receive channel of an ARINC 429 style serial bus. It takes the two line levels, HI and LO, after they have been sliced to logic levels. Each lane passes through a two-flop synchronizer and a spike filter. The channel then decodes return-to-zero bits: a filtered HI pulse is a one and a filtered LO pulse is a zero. It packs the bits into a 32-bit word and closes the word once the line has stayed idle for a set number of bit times. The finished word is placed in a hold register together with a 3-bit error code. The host reads the word and acknowledges it with a one-cycle take pulse.

A configuration strobe loads two settings. The first picks the high or the low bit rate. The second routes an externally generated test stream into the decoder in place of the line lanes. The filter, the bit decoder and the gap timer all run on a base tick at sixteen times the selected bit rate. A prescaler derives that tick from the system clock.

Top module: `arx_rx_channel`

## Requirements
- R1: After reset, `word_valid` is 0 and `word_code` is 000. The channel receives at the low bit rate from the line lanes until a configuration write changes this.
- R2: A word of exactly 32 bits with odd parity over all 32 bits is held with code 000. The first bit received sits at `word_data[0]` and the last at `word_data[31]`. `word_valid` rises when the word closes.
- R3: A 32-bit word with even parity over all 32 bits is held with code 010 (parity error).
- R4: A word that closes with a bit count other than 32, including one where a 33rd bit arrives before the gap, is held with code 011 (length error).
- R5: If both filtered lanes are high at any tick during a word, that word is held with code 101 (wiring fault).
- R6: If a word closes while the previous held word has not been taken, the new word replaces it and is held with code 100 (channel overrun).
- R7: If the held word is still untaken when the next word begins, and is taken before that word closes, the new word is held with code 001 (late service).
- R8: When several conditions apply, only the highest is coded. The order from highest to lowest is 101, 100, 011, 010, 001. Codes 110 and 111 never appear.
- R9: A pulse on either lane shorter than 3 base ticks is ignored. It neither adds a bit nor restarts the gap timer.
- R10: With the high rate selected, the base tick runs at `HI_DIV` clocks instead of `LO_DIV`. Words sent at that rate decode correctly.
- R11: With test routing selected, the test lanes feed the decoder and the line lanes have no effect, even when both line lanes are held high.
- R12: A word closes only after both filtered lanes have been low for 3 bit times (48 base ticks). An idle time of 2 bit times does not close it.
- R13: A take pulse clears `word_valid`. The held data and code change only when a word closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Loads `cfg_fast` and `cfg_test` |
| cfg_fast | input | 1 | 1 selects the high bit rate |
| cfg_test | input | 1 | 1 routes the test lanes to the decoder |
| line_hi | input | 1 | Sliced HI level of the bus line |
| line_lo | input | 1 | Sliced LO level of the bus line |
| tst_hi | input | 1 | HI lane of the injected test stream |
| tst_lo | input | 1 | LO lane of the injected test stream |
| word_take | input | 1 | One-cycle acknowledge of the held word |
| word_valid | output | 1 | The hold register contains an unread word |
| word_data | output | 32 | Held word, first received bit in bit 0 |
| word_code | output | 3 | Error code of the held word |

## Verification
The assertions assume that `word_take` is a single-cycle pulse. They also assume that a configuration write happens only while the line is idle, so the tick rate never changes in the middle of a word. The stimulus drives the lanes on falling clock edges, in whole base ticks. Bits are 8 ticks active followed by 8 ticks null, and every inter-word gap is 4 bit times. Every deliberate spike is 2 ticks long, and the rate or routing is changed only between words.

// File: rtl/arx_pkg.sv
`timescale 1ns/1ps
package arx_pkg;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'b000,
    ERR_SVC   = 3'b001,
    ERR_PAR   = 3'b010,
    ERR_LEN   = 3'b011,
    ERR_CHOVR = 3'b100,
    ERR_WIRE  = 3'b101
  } arx_err_e;

  // Highest applicable condition wins.
  function automatic arx_err_e err_pick(input logic wire_f, input logic chovr,
                                        input logic len_bad, input logic par_bad,
                                        input logic svc);
    if (wire_f)       return ERR_WIRE;
    else if (chovr)   return ERR_CHOVR;
    else if (len_bad) return ERR_LEN;
    else if (par_bad) return ERR_PAR;
    else if (svc)     return ERR_SVC;
    else              return ERR_NONE;
  endfunction

endpackage

// File: rtl/arx_tick_gen.sv
`timescale 1ns/1ps
module arx_tick_gen #(
  parameter int HI_DIV = 2,
  parameter int LO_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  output logic tick
);
  localparam int MAXD  = (HI_DIV > LO_DIV) ? HI_DIV : LO_DIV;
  localparam int DIV_W = $clog2(MAXD + 1);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick = (cnt_q == '0);
    if (tick) cnt_d = fast ? DIV_W'(HI_DIV - 1) : DIV_W'(LO_DIV - 1);
    else      cnt_d = cnt_q - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/arx_spike_filter.sv
`timescale 1ns/1ps
module arx_spike_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (tick) begin
      if (raw != out_q) begin
        if (cnt_q == CW'(FILT_LEN - 1)) begin
          out_d = raw;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign clean = out_q;
endmodule

// File: rtl/arx_word_asm.sv
`timescale 1ns/1ps
module arx_word_asm #(
  parameter int WORD_BITS = 32,
  parameter int GAP_TICKS = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 f_hi,
  input  logic                 f_lo,
  output logic                 done,
  output logic                 start,
  output logic [WORD_BITS-1:0] shreg,
  output logic                 len_ok,
  output logic                 par_odd,
  output logic                 fault
);
  localparam int CNT_W  = $clog2(WORD_BITS + 2);
  localparam int IDLE_W = $clog2(GAP_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_BITS + 1);

  logic                 prev_hi_q, prev_hi_d, prev_lo_q, prev_lo_d;
  logic                 busy_q, busy_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [IDLE_W-1:0]    idle_q, idle_d;
  logic [WORD_BITS-1:0] sh_q, sh_d;
  logic                 par_q, par_d;
  logic                 flt_q, flt_d;
  logic                 done_q, done_d;
  logic                 start_q, start_d;
  logic                 rise_hi, rise_lo;

  assign rise_hi = f_hi & ~prev_hi_q;
  assign rise_lo = f_lo & ~prev_lo_q;

  always_comb begin
    prev_hi_d = prev_hi_q;
    prev_lo_d = prev_lo_q;
    busy_d    = busy_q;
    cnt_d     = cnt_q;
    idle_d    = idle_q;
    sh_d      = sh_q;
    par_d     = par_q;
    flt_d     = flt_q;
    done_d    = 1'b0;
    start_d   = 1'b0;
    if (tick) begin
      prev_hi_d = f_hi;
      prev_lo_d = f_lo;
      if (f_hi | f_lo) begin
        idle_d = '0;
        if (!busy_q) begin
          busy_d  = 1'b1;
          start_d = 1'b1;
          cnt_d   = '0;
          par_d   = 1'b0;
          flt_d   = 1'b0;
          sh_d    = '0;
        end
        if (f_hi & f_lo) flt_d = 1'b1;
        if (rise_hi | rise_lo) begin
          sh_d  = {rise_hi, sh_d[WORD_BITS-1:1]};
          par_d = par_d ^ rise_hi;
          if (cnt_d != CNT_MAX) cnt_d = cnt_d + CNT_W'(1);
        end
      end else if (busy_q) begin
        if (idle_q == IDLE_W'(GAP_TICKS - 1)) begin
          busy_d = 1'b0;
          done_d = 1'b1;
          idle_d = '0;
        end else begin
          idle_d = idle_q + IDLE_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_hi_q <= 1'b0;
      prev_lo_q <= 1'b0;
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      idle_q    <= '0;
      sh_q      <= '0;
      par_q     <= 1'b0;
      flt_q     <= 1'b0;
      done_q    <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      prev_hi_q <= prev_hi_d;
      prev_lo_q <= prev_lo_d;
      busy_q    <= busy_d;
      cnt_q     <= cnt_d;
      idle_q    <= idle_d;
      sh_q      <= sh_d;
      par_q     <= par_d;
      flt_q     <= flt_d;
      done_q    <= done_d;
      start_q   <= start_d;
    end
  end

  assign done    = done_q;
  assign start   = start_q;
  assign shreg   = sh_q;
  assign len_ok  = (cnt_q == CNT_W'(WORD_BITS));
  assign par_odd = par_q;
  assign fault   = flt_q;
endmodule

// File: rtl/arx_rx_channel.sv
`timescale 1ns/1ps
module arx_rx_channel
  import arx_pkg::*;
#(
  parameter int HI_DIV        = 2,
  parameter int LO_DIV        = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int GAP_BITS      = 3,
  parameter int FILT_LEN      = 3,
  parameter int WORD_BITS     = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_fast,
  input  logic                 cfg_test,
  input  logic                 line_hi,
  input  logic                 line_lo,
  input  logic                 tst_hi,
  input  logic                 tst_lo,
  input  logic                 word_take,
  output logic                 word_valid,
  output logic [WORD_BITS-1:0] word_data,
  output logic [2:0]           word_code
);
  localparam int GAP_TICKS = GAP_BITS * TICKS_PER_BIT;
  localparam int LANES     = 2;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rs_q1, rs_q2, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_i_n = rs_q2;

  // Configuration.
  logic fast_q, fast_d, test_q, test_d;
  always_comb begin
    fast_d = fast_q;
    test_d = test_q;
    if (cfg_we) begin
      fast_d = cfg_fast;
      test_d = cfg_test;
    end
  end
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      fast_q <= 1'b0;
      test_q <= 1'b0;
    end else begin
      fast_q <= fast_d;
      test_q <= test_d;
    end
  end

  logic tick;
  arx_tick_gen #(.HI_DIV(HI_DIV), .LO_DIV(LO_DIV)) u_tick (
    .clk(clk), .rst_n(rst_i_n), .fast(fast_q), .tick(tick)
  );

  // Lane 0 = HI, lane 1 = LO.
  logic [LANES-1:0] lane_raw, sync1_q, sync2_q, lane_clean;
  assign lane_raw = test_q ? {tst_lo, tst_hi} : {line_lo, line_hi};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n) begin
        sync1_q[g] <= 1'b0;
        sync2_q[g] <= 1'b0;
      end else begin
        sync1_q[g] <= lane_raw[g];
        sync2_q[g] <= sync1_q[g];
      end
    end
    arx_spike_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_i_n), .tick(tick),
      .raw(sync2_q[g]), .clean(lane_clean[g])
    );
  end

  logic                 asm_done, asm_start, asm_len_ok, asm_par_odd, asm_fault;
  logic [WORD_BITS-1:0] asm_data;
  arx_word_asm #(.WORD_BITS(WORD_BITS), .GAP_TICKS(GAP_TICKS)) u_asm (
    .clk(clk), .rst_n(rst_i_n), .tick(tick),
    .f_hi(lane_clean[0]), .f_lo(lane_clean[1]),
    .done(asm_done), .start(asm_start), .shreg(asm_data),
    .len_ok(asm_len_ok), .par_odd(asm_par_odd), .fault(asm_fault)
  );

  // Hold register with error coding.
  logic                 hv_q, hv_d, pend_q, pend_d;
  logic [WORD_BITS-1:0] hd_q, hd_d;
  arx_err_e             hc_q, hc_d;
  logic                 chovr;

  assign chovr = hv_q & ~word_take;

  always_comb begin
    hv_d   = hv_q;
    hd_d   = hd_q;
    hc_d   = hc_q;
    pend_d = pend_q;
    if (asm_start) pend_d = hv_q & ~word_take;
    if (asm_done) begin
      hv_d   = 1'b1;
      hd_d   = asm_data;
      hc_d   = err_pick(asm_fault, chovr, ~asm_len_ok, ~asm_par_odd, pend_q);
      pend_d = 1'b0;
    end else if (word_take) begin
      hv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      hv_q   <= 1'b0;
      hd_q   <= '0;
      hc_q   <= ERR_NONE;
      pend_q <= 1'b0;
    end else begin
      hv_q   <= hv_d;
      hd_q   <= hd_d;
      hc_q   <= hc_d;
      pend_q <= pend_d;
    end
  end

  assign word_valid = hv_q;
  assign word_data  = hd_q;
  assign word_code  = hc_q;
endmodule

// File: rtl/arx_rx_channel_chk.sv
`timescale 1ns/1ps
module arx_rx_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        fault,
  input logic        take,
  input logic        valid,
  input logic [31:0] data,
  input logic [2:0]  code
);
  // R2
  done_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> valid);

  // R13
  take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !done) |=> !valid);

  // R13
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(data) && $stable(code));

  // R8
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (code <= 3'd5));

  // R6
  overrun_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && valid && !take) |=> (code == 3'b100 || code == 3'b101));

  // R5
  wire_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |=> (code == 3'b101));
endmodule

bind arx_rx_channel arx_rx_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(asm_done), .fault(asm_fault),
  .take(word_take), .valid(word_valid), .data(word_data), .code(word_code)
);

// File: tb/sim_arx_rx_channel.sv
`timescale 1ns/1ps
module sim_arx_rx_channel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_fast, cfg_test;
  logic        line_hi, line_lo, tst_hi, tst_lo;
  logic        word_take;
  logic        word_valid;
  logic [31:0] word_data;
  logic [2:0]  word_code;

  int checks = 0;
  int failures = 0;
  int cur_div = 8;
  bit to_test = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  arx_rx_channel u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_fast(cfg_fast),
    .cfg_test(cfg_test), .line_hi(line_hi), .line_lo(line_lo),
    .tst_hi(tst_hi), .tst_lo(tst_lo), .word_take(word_take),
    .word_valid(word_valid), .word_data(word_data), .word_code(word_code)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n * cur_div) @(negedge clk);
  endtask

  task automatic drive(input logic h, input logic l);
    if (to_test) begin tst_hi = h; tst_lo = l; end
    else begin line_hi = h; line_lo = l; end
  endtask

  // Sends bits[first..last]; fault_at marks one bit sent with both lanes high.
  task automatic send_range(input logic [39:0] bits, input int first, input int last,
                            input bit spikes, input int fault_at);
    for (int i = first; i <= last; i++) begin
      if (i == fault_at) drive(1'b1, 1'b1);
      else drive(bits[i], ~bits[i]);
      ticks(8);
      drive(1'b0, 1'b0);
      if (spikes) begin
        ticks(3);
        drive(~bits[i], bits[i]);
        ticks(2);
        drive(1'b0, 1'b0);
        ticks(3);
      end else begin
        ticks(8);
      end
    end
  endtask

  task automatic gap(input int nbits, input bit spikes);
    drive(1'b0, 1'b0);
    if (spikes) begin
      ticks(10); drive(1'b1, 1'b0); ticks(2); drive(1'b0, 1'b0);
      ticks(10); drive(1'b0, 1'b1); ticks(2); drive(1'b0, 1'b0);
      ticks(16 * nbits - 24);
    end else begin
      ticks(16 * nbits);
    end
  endtask

  task automatic send_word(input logic [39:0] bits, input int n, input bit spikes,
                           input int fault_at);
    send_range(bits, 0, n - 1, spikes, fault_at);
    gap(4, spikes);
  endtask

  task automatic take_word();
    @(negedge clk); word_take = 1'b1;
    @(negedge clk); word_take = 1'b0;
  endtask

  task automatic cfg(input bit fast, input bit tst);
    @(negedge clk); cfg_we = 1'b1; cfg_fast = fast; cfg_test = tst;
    @(negedge clk); cfg_we = 1'b0;
    cur_div = fast ? 2 : 8;
    to_test = tst;
    ticks(4);
  endtask

  function automatic logic [31:0] odd_word(input logic [30:0] d);
    return {~(^d), d};
  endfunction

  function automatic logic [31:0] even_word(input logic [30:0] d);
    return {^d, d};
  endfunction

  task automatic t_reset();
    chk(word_valid == 1'b0, "R1 valid after reset", 32'(word_valid), 32'd0);
    chk(word_code == 3'b000, "R1 code after reset", 32'(word_code), 32'd0);
  endtask

  task automatic t_good();
    logic [31:0] w = odd_word(31'h2A5C_31E7);
    // Default low rate, line lanes (R1).
    send_word({8'h0, w}, 32, 1'b0, -1);
    chk(word_valid == 1'b1, "R1 R2 valid", 32'(word_valid), 32'd1);
    chk(word_data == w, "R2 data", word_data, w);
    chk(word_code == 3'b000, "R2 code", 32'(word_code), 32'd0);
    take_word();
    chk(word_valid == 1'b0, "R13 take clears", 32'(word_valid), 32'd0);
    chk(word_data == w, "R13 data kept", word_data, w);
  endtask

  task automatic t_parity();
    logic [31:0] w = even_word(31'h0123_4567);
    send_word({8'h0, w}, 32, 1'b0, -1);
    chk(word_code == 3'b010, "R3 even parity", 32'(word_code), 32'd2);
    chk(word_data == w, "R3 data", word_data, w);
    take_word();
  endtask

  task automatic t_length();
    logic [31:0] w = odd_word(31'h5555_0F0F);
    send_word({8'h0, w}, 31, 1'b0, -1);
    chk(word_code == 3'b011, "R4 short word", 32'(word_code), 32'd3);
    take_word();
    send_word({8'h01, w}, 33, 1'b0, -1);
    chk(word_code == 3'b011, "R4 33rd bit", 32'(word_code), 32'd3);
    take_word();
  endtask

  task automatic t_wire();
    logic [31:0] w = odd_word(31'h7000_0001);
    send_word({8'h0, w}, 32, 1'b0, 5);
    chk(word_code == 3'b101, "R5 both lanes high", 32'(word_code), 32'd5);
    take_word();
  endtask

  task automatic t_prio();
    // 31 bits with two ones: length and parity both bad -> length wins.
    send_word(40'h3, 31, 1'b0, -1);
    chk(word_code == 3'b011, "R8 length over parity", 32'(word_code), 32'd3);
    take_word();
    send_word(40'h3, 31, 1'b0, 2);
    chk(word_code == 3'b101, "R8 wiring over length", 32'(word_code), 32'd5);
    take_word();
  endtask

  task automatic t_chovr();
    logic [31:0] w1 = odd_word(31'h1111_2222);
    logic [31:0] w2 = odd_word(31'h3333_4444);
    send_word({8'h0, w1}, 32, 1'b0, -1);
    send_word({8'h0, w2}, 32, 1'b0, -1);
    chk(word_code == 3'b100, "R6 overrun code", 32'(word_code), 32'd4);
    chk(word_data == w2, "R6 new word kept", word_data, w2);
    take_word();
  endtask

  task automatic t_svc();
    logic [31:0] w1 = odd_word(31'h0BAD_F00D);
    logic [31:0] w2 = odd_word(31'h600D_CAFE);
    send_word({8'h0, w1}, 32, 1'b0, -1);
    send_range({8'h0, w2}, 0, 15, 1'b0, -1);
    take_word();
    send_range({8'h0, w2}, 16, 31, 1'b0, -1);
    gap(4, 1'b0);
    chk(word_code == 3'b001, "R7 late service", 32'(word_code), 32'd1);
    chk(word_data == w2, "R7 data", word_data, w2);
    take_word();
  endtask

  task automatic t_spike();
    logic [31:0] w = odd_word(31'h4C3B_2A19);
    send_word({8'h0, w}, 32, 1'b1, -1);
    chk(word_valid == 1'b1, "R9 valid", 32'(word_valid), 32'd1);
    chk(word_data == w, "R9 spikes ignored data", word_data, w);
    chk(word_code == 3'b000, "R9 spikes ignored code", 32'(word_code), 32'd0);
    take_word();
  endtask

  task automatic t_speed();
    logic [31:0] w = odd_word(31'h1357_9BDF);
    cfg(1'b1, 1'b0);
    send_word({8'h0, w}, 32, 1'b0, -1);
    chk(word_data == w, "R10 fast data", word_data, w);
    chk(word_code == 3'b000, "R10 fast code", 32'(word_code), 32'd0);
    take_word();
    cfg(1'b0, 1'b0);
  endtask

  task automatic t_test();
    logic [31:0] w = odd_word(31'h0246_8ACE);
    cfg(1'b0, 1'b1);
    line_hi = 1'b1; line_lo = 1'b1;
    send_word({8'h0, w}, 32, 1'b0, -1);
    chk(word_data == w, "R11 test lane data", word_data, w);
    chk(word_code == 3'b000, "R11 line ignored", 32'(word_code), 32'd0);
    take_word();
    line_hi = 1'b0; line_lo = 1'b0;
    cfg(1'b0, 1'b0);
  endtask

  task automatic t_gap();
    logic [31:0] w = odd_word(31'h7ACE_0101);
    send_range({8'h0, w}, 0, 31, 1'b0, -1);
    ticks(32);
    chk(word_valid == 1'b0, "R12 open after 2 bit times", 32'(word_valid), 32'd0);
    ticks(32);
    chk(word_valid == 1'b1, "R12 closed after 3 bit times", 32'(word_valid), 32'd1);
    chk(word_data == w, "R12 data", word_data, w);
    take_word();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_fast = 1'b0; cfg_test = 1'b0;
    line_hi = 1'b0; line_lo = 1'b0; tst_hi = 1'b0; tst_lo = 1'b0;
    word_take = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    t_reset();
    t_good();
    t_parity();
    t_length();
    t_wire();
    t_prio();
    t_chovr();
    t_svc();
    t_spike();
    t_speed();
    t_test();
    t_gap();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule